// File: doc/BRIEF.md
# Pulse-Width Bus Transmitter with Priority Arbitration

This block sends one frame of bytes on a single-wire, variable-pulse-width vehicle bus at the nominal 10.4 kbit/s rate. The bus has no master. Nodes share it by sensing the carrier, and when two start together the one with the higher-priority message wins. The bus is driven high (active) through an external transceiver. Active is dominant over passive. Every symbol length is counted in pulses of the `tick_en` enable input, so the logic runs on a single system clock and the bit time is set by how often `tick_en` fires.

A frame is requested by holding `send_req` high with `frame_len` stable. While the frame is sent, the block addresses the byte it needs through `byte_idx` and reads that byte on `byte_data`. The block first waits until the synchronised receive line has been passive for a full inter-frame idle period. It then sends a long active start symbol, followed by the data bits MSB first with the bus level alternating on every bit, and ends with a passive end-of-data period. During each passive symbol the block watches the bus. If it sees active after a short tolerance, another node has won the bus. The block then stops at once, reports `arb_lost`, waits for a new idle period and sends the whole frame again, without the requester doing anything.

States: IDLE (no request), WAIT (listening for bus idle), SOF (start symbol), BITS (data symbols), EOD (end-of-data), LOST (one-cycle loss report), DONE (one-cycle completion). Transitions: IDLE→WAIT on request; WAIT→IDLE if the request is withdrawn; WAIT→SOF on a tick with the bus idle; SOF→BITS at symbol end; BITS→EOD at the end of the last bit; BITS→LOST and EOD→LOST on arbitration loss; EOD→DONE at symbol end; LOST→WAIT and DONE→IDLE unconditionally.

Top module: `vpw_arb_tx`

## Requirements
- R1: After reset `bus_tx`, `busy`, `done` and `arb_lost` are 0 and `byte_idx` is 0.
- R2: A frame starts only on a tick after `bus_rx` has been passive for IDLE_T consecutive ticks (default 300). The start comes IDLE_T to IDLE_T+2 ticks after the bus goes quiet, or within 2 ticks of the request if the bus has already been quiet long enough.
- R3: The start-of-frame symbol drives `bus_tx` high for exactly SOF_T ticks (default 200).
- R4: Data bits go out MSB first, starting with byte 0. The first bit is passive (`bus_tx`=0) and the level alternates on every bit. A passive bit lasts SHORT_T ticks for 0 and LONG_T ticks for 1. An active bit lasts LONG_T ticks for 0 and SHORT_T ticks for 1 (defaults 64 and 128).
- R5: After the last bit, `bus_tx` stays passive for EOD_T ticks (default 200). `done` then pulses for one cycle and `busy` is 0 in the next cycle.
- R6: If `bus_rx` is active while the block is in a passive data or end-of-data symbol, and at least TOL_T ticks of that symbol have passed, `arb_lost` pulses once. `bus_tx` then stays 0 while the other node finishes its frame.
- R7: After a loss the block stays busy, waits for IDLE_T quiet ticks again and resends the whole frame from byte 0 (`byte_idx`=0).
- R8: An active `bus_rx` seen within the first TOL_T ticks of a passive symbol is ignored. A node sending an identical frame in step causes no loss.
- R9: `busy` is high from the accepted request until `done`. `bus_tx` is never high while `busy` is low. `done` and `arb_lost` are never high together.
- R10: `byte_idx` equals the index of the byte whose bits are on the bus. It changes at the first bit of each new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing enable pulse; all symbol lengths count these |
| send_req | input | 1 | Frame pending; held high until `done` |
| frame_len | input | LEN_W | Number of bytes in the frame, 1 to MAX_BYTES |
| byte_idx | output | IDX_W | Index of the byte being sent |
| byte_data | input | 8 | Byte at `byte_idx` |
| bus_rx | input | 1 | Received bus level from the transceiver, 1 = active |
| bus_tx | output | 1 | Transmit level to the transceiver, 1 = active |
| busy | output | 1 | A frame is in progress (listening, sending or retrying) |
| done | output | 1 | One-cycle pulse when the frame has been sent |
| arb_lost | output | 1 | One-cycle pulse when arbitration is lost |

## Verification
The bench sends frames with no other node on the bus, against a second node sending an identical frame in step, against a node that wins at a random bit, and against a node that loses at a random bit. These four cases separate a correct arbitration decision from a false loss caused by loopback delay, and from a missed loss. Directed cases hold the bus busy across a request to measure the listening delay, start on an already quiet bus, and send a maximum-length frame to test the byte index. Random tick periods of two and three clocks show that every length is counted in ticks and not in clocks.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SOF,
        ST_BITS,
        ST_EOD,
        ST_LOST,
        ST_DONE
    } tx_state_e;

    typedef enum logic [1:0] {
        SYM_SOF,
        SYM_BIT,
        SYM_EOD
    } sym_kind_e;

endpackage

// File: rtl/vpw_bus_sense.sv
// Synchronises the received bus level and counts consecutive passive ticks.
module vpw_bus_sense #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_T      = 300,
    parameter int CNT_W       = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic rx_act,
    output logic bus_idle
);
    localparam logic [CNT_W-1:0] IDLE_C = CNT_W'(IDLE_T);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
        end
    end

    assign rx_act = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (rx_act) begin
            quiet_q <= '0;
        end else if (tick && (quiet_q != IDLE_C)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign bus_idle = (quiet_q == IDLE_C);

endmodule

// File: rtl/vpw_sym_len.sv
// Picks the length in ticks of the symbol now on the bus.
module vpw_sym_len
    import vpw_tx_pkg::*;
#(
    parameter int SHORT_T = 64,
    parameter int LONG_T  = 128,
    parameter int SOF_T   = 200,
    parameter int EOD_T   = 200,
    parameter int CNT_W   = 9
) (
    input  sym_kind_e        kind,
    input  logic             act_lvl,
    input  logic             bit_val,
    output logic [CNT_W-1:0] len
);
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_T);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_T);
    localparam logic [CNT_W-1:0] SOF_C   = CNT_W'(SOF_T);
    localparam logic [CNT_W-1:0] EOD_C   = CNT_W'(EOD_T);

    always_comb begin
        unique case (kind)
            SYM_SOF: len = SOF_C;
            SYM_EOD: len = EOD_C;
            default: len = (act_lvl ^ bit_val) ? LONG_C : SHORT_C;
        endcase
    end

endmodule

// File: rtl/vpw_sym_timer.sv
// Counts ticks within a symbol and flags the tick that ends it.
module vpw_sym_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic [CNT_W-1:0] len,
    output logic             sym_end,
    output logic [CNT_W-1:0] elapsed
);
    logic at_last;

    assign at_last = (elapsed == (len - 1'b1));
    assign sym_end = !hold && tick && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (hold || sym_end) begin
            elapsed <= '0;
        end else if (tick) begin
            elapsed <= elapsed + 1'b1;
        end
    end

endmodule

// File: rtl/vpw_arb_tx.sv
module vpw_arb_tx
    import vpw_tx_pkg::*;
#(
    parameter int SHORT_T     = 64,
    parameter int LONG_T      = 128,
    parameter int SOF_T       = 200,
    parameter int EOD_T       = 200,
    parameter int IDLE_T      = 300,
    parameter int TOL_T       = 8,
    parameter int MAX_BYTES   = 12,
    parameter int SYNC_STAGES = 2,
    localparam int MAX_A      = (SOF_T > EOD_T) ? SOF_T : EOD_T,
    localparam int MAX_B      = (LONG_T > IDLE_T) ? LONG_T : IDLE_T,
    localparam int MAX_T      = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int CNT_W      = $clog2(MAX_T + 1),
    localparam int IDX_W      = $clog2(MAX_BYTES),
    localparam int LEN_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             send_req,
    input  logic [LEN_W-1:0] frame_len,
    output logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_data,
    input  logic             bus_rx,
    output logic             bus_tx,
    output logic             busy,
    output logic             done,
    output logic             arb_lost
);
    localparam logic [CNT_W-1:0] TOL_C = CNT_W'(TOL_T);

    tx_state_e        state, nxt;
    logic [2:0]       bit_pos;
    logic [IDX_W-1:0] idx_q;
    logic             sym_act;

    logic             rx_act;
    logic             bus_idle;
    logic             sym_end;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] sym_len;
    logic             timer_hold;
    sym_kind_e        kind;
    logic             cur_bit;
    logic             last_bit;
    logic             own_passive;
    logic             lose;
    logic [LEN_W-1:0] last_idx;

    vpw_bus_sense #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_T      (IDLE_T),
        .CNT_W       (CNT_W)
    ) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .rx_in    (bus_rx),
        .rx_act   (rx_act),
        .bus_idle (bus_idle)
    );

    vpw_sym_len #(
        .SHORT_T (SHORT_T),
        .LONG_T  (LONG_T),
        .SOF_T   (SOF_T),
        .EOD_T   (EOD_T),
        .CNT_W   (CNT_W)
    ) u_len (
        .kind    (kind),
        .act_lvl (sym_act),
        .bit_val (cur_bit),
        .len     (sym_len)
    );

    vpw_sym_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .hold    (timer_hold),
        .len     (sym_len),
        .sym_end (sym_end),
        .elapsed (elapsed)
    );

    // Symbol selection and the arbitration decision
    assign cur_bit     = byte_data[3'd7 - bit_pos];
    assign last_idx    = frame_len - 1'b1;
    assign last_bit    = (bit_pos == 3'd7) && (LEN_W'(idx_q) == last_idx);
    assign own_passive = ((state == ST_BITS) && !sym_act) || (state == ST_EOD);
    assign lose        = own_passive && rx_act && (elapsed >= TOL_C);
    assign timer_hold  = !((state == ST_SOF) || (state == ST_BITS) || (state == ST_EOD));

    always_comb begin
        unique case (state)
            ST_BITS: kind = SYM_BIT;
            ST_EOD:  kind = SYM_EOD;
            default: kind = SYM_SOF;
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (send_req) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!send_req)                nxt = ST_IDLE;
                else if (tick_en && bus_idle) nxt = ST_SOF;
            end
            ST_SOF:  if (sym_end) nxt = ST_BITS;
            ST_BITS: begin
                if (lose)                     nxt = ST_LOST;
                else if (sym_end && last_bit) nxt = ST_EOD;
            end
            ST_EOD: begin
                if (lose)         nxt = ST_LOST;
                else if (sym_end) nxt = ST_DONE;
            end
            ST_LOST: nxt = ST_WAIT;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register with the bit and byte position that belong to it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_pos <= '0;
            idx_q   <= '0;
            sym_act <= 1'b0;
        end else begin
            state <= nxt;
            if ((state == ST_IDLE) || (state == ST_LOST) || (nxt == ST_SOF)) begin
                bit_pos <= '0;
                idx_q   <= '0;
                sym_act <= 1'b0;
            end else if ((state == ST_BITS) && sym_end && !lose && !last_bit) begin
                bit_pos <= bit_pos + 1'b1;
                sym_act <= !sym_act;
                if (bit_pos == 3'd7) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        bus_tx   = (state == ST_SOF) || ((state == ST_BITS) && sym_act);
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        arb_lost = (state == ST_LOST);
        byte_idx = idx_q;
    end

endmodule

// File: rtl/vpw_arb_tx_chk.sv
module vpw_arb_tx_chk
    import vpw_tx_pkg::*;
#(
    parameter int SHORT_T = 64,
    parameter int LONG_T  = 128,
    parameter int SOF_T   = 200,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_tx,
    input  logic             busy,
    input  logic             done,
    input  logic             arb_lost,
    input  logic [IDX_W-1:0] byte_idx,
    input  tx_state_e        state,
    input  logic             bus_idle
);
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_cnt <= 0;
        else if (!bus_tx) hi_cnt <= 0;
        else if (tick_en) hi_cnt <= hi_cnt + 1;
    end

    // R2
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_tx) && ($past(state) == ST_WAIT)) |-> $past(bus_idle));

    // R4
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_tx) |-> ((hi_cnt == SHORT_T) || (hi_cnt == LONG_T) || (hi_cnt == SOF_T)));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    lost_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!bus_tx && !$past(bus_tx)));

    // R7
    retry_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> (busy && (byte_idx == '0)));

    // R9
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_tx);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && arb_lost));

endmodule

bind vpw_arb_tx vpw_arb_tx_chk #(
    .SHORT_T (SHORT_T),
    .LONG_T  (LONG_T),
    .SOF_T   (SOF_T),
    .IDX_W   (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_tx   (bus_tx),
    .busy     (busy),
    .done     (done),
    .arb_lost (arb_lost),
    .byte_idx (byte_idx),
    .state    (state),
    .bus_idle (bus_idle)
);

// File: tb/test_vpw_arb_tx.sv
`timescale 1ns/1ps
module test_vpw_arb_tx;
    localparam int SHORT_T = 64;
    localparam int LONG_T  = 128;
    localparam int SOF_T   = 200;
    localparam int EOD_T   = 200;
    localparam int IDLE_T  = 300;
    localparam int MAXB    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       send_req = 1'b0;
    logic [3:0] frame_len = 4'd1;
    logic [3:0] byte_idx;
    logic [7:0] byte_data;
    logic       bus_tx, busy, done, arb_lost;
    logic       oth = 1'b0;
    logic       comp_done = 1'b0;
    logic [7:0] fr [16];
    logic [7:0] cf [16];
    int         tp = 2;
    int         tick_ctr = 0;
    int         nchk = 0;
    int         nfail = 0;
    int         arb_seen = 0;

    always #5 clk = ~clk;

    assign byte_data = fr[byte_idx];

    vpw_arb_tx i_vpw_arb_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .send_req  (send_req),
        .frame_len (frame_len),
        .byte_idx  (byte_idx),
        .byte_data (byte_data),
        .bus_rx    (bus_tx | oth),
        .bus_tx    (bus_tx),
        .busy      (busy),
        .done      (done),
        .arb_lost  (arb_lost)
    );

    always @(negedge clk) begin
        tick_ctr <= (tick_ctr >= tp - 1) ? 0 : tick_ctr + 1;
        tick_en  <= (tick_ctr >= tp - 1);
        if (arb_lost) arb_seen <= arb_seen + 1;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_len(input bit lvl, input bit b);
        return (lvl ^ b) ? LONG_T : SHORT_T;
    endfunction

    function automatic bit fbit(input bit comp, input int i);
        return comp ? cf[i / 8][7 - (i % 8)] : fr[i / 8][7 - (i % 8)];
    endfunction

    task automatic measure(input bit lvl, output int n);
        n = 0;
        while (bus_tx == lvl) begin
            if (tick_en) n++;
            step();
        end
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        while (!bus_tx) begin
            if (tick_en) n++;
            step();
        end
    endtask

    // Called at the sample where bus_tx has just risen for a start symbol.
    task automatic check_frame(input int len);
        int n;
        measure(1'b1, n);
        chk(n == SOF_T, "R3 start symbol ticks", n, SOF_T);
        for (int i = 0; i < 8 * len; i++) begin
            if (i % 8 == 0)
                chk(byte_idx == 4'(i / 8), "R10 byte index", int'(byte_idx), i / 8);
            measure(1'(i % 2), n);
            chk(n == exp_len(1'(i % 2), fbit(1'b0, i)), "R4 bit symbol ticks", n,
                exp_len(1'(i % 2), fbit(1'b0, i)));
        end
        n = 0;
        while (!done) begin
            if (tick_en) n++;
            step();
        end
        chk(n == EOD_T, "R5 end-of-data ticks", n, EOD_T);
        send_req = 1'b0;
        step();
        chk(!busy, "R5 busy after done", int'(busy), 0);
    endtask

    task automatic comp_sym(input bit lvl, input int len);
        int c = 0;
        oth = lvl;
        while (c < len) begin
            step();
            if (tick_en) c++;
        end
    endtask

    task automatic comp_drive(input int len, input int stop);
        int last = (stop < 0) ? 8 * len - 1 : stop;
        while (!bus_tx) step();
        comp_sym(1'b1, SOF_T);
        for (int i = 0; i <= last; i++)
            comp_sym(1'(i % 2), exp_len(1'(i % 2), fbit(1'b1, i)));
        oth = 1'b0;
        comp_done = 1'b1;
    endtask

    // mode 0: alone, 1: identical competitor, 2: competitor wins, 3: block wins
    task automatic run_trial(input int len, input int mode);
        int k = 0, n, base, bad = 0;
        bit lost = 1'b0;
        for (int b = 0; b < len; b++) begin
            fr[b] = 8'($urandom);
            cf[b] = fr[b];
        end
        if (mode >= 2) begin
            k = int'($urandom % (8 * len));
            fr[k / 8][7 - (k % 8)] = (mode == 2);
            cf[k / 8][7 - (k % 8)] = (mode == 3);
        end
        tp = 2 + int'($urandom % 2);
        comp_done = 1'b0;
        base = arb_seen;
        frame_len = 4'(len);
        send_req = 1'b1;
        fork
            begin
                if (mode != 0) comp_drive(len, (mode == 3) ? k : -1);
            end
            begin
                wait_rise(n);
                if (mode == 2) begin
                    while (!comp_done) begin
                        if (lost && bus_tx) bad++;
                        if (arb_lost) lost = 1'b1;
                        step();
                    end
                    chk(lost, "R6 loss reported", int'(lost), 1);
                    chk(bad == 0, "R6 silent after loss", bad, 0);
                    chk(busy, "R7 still busy after loss", int'(busy), 1);
                    wait_rise(n);
                    chk(n >= IDLE_T && n <= IDLE_T + 2, "R7 retry quiet ticks", n, IDLE_T);
                    chk(byte_idx == 4'd0, "R7 retry from byte 0", int'(byte_idx), 0);
                end
                check_frame(len);
            end
        join
        chk((arb_seen - base) == ((mode == 2) ? 1 : 0),
            (mode == 1) ? "R8 tie causes no loss" : "R6 loss count",
            arb_seen - base, (mode == 2) ? 1 : 0);
    endtask

    initial begin
        int n;
        void'($urandom(32'h5A17));
        for (int b = 0; b < 16; b++) begin
            fr[b] = 8'h00;
            cf[b] = 8'h00;
        end
        repeat (4) @(posedge clk);
        #1;
        chk(!bus_tx && !busy && !done && !arb_lost && byte_idx == 4'd0,
            "R1 reset outputs", int'({bus_tx, busy, done, arb_lost}), 0);
        rst_n = 1'b1;
        step();
        chk(!bus_tx && !busy && !done && !arb_lost, "R1 after reset release",
            int'({bus_tx, busy, done, arb_lost}), 0);

        // R2 / R9: bus held busy across a request
        fr[0] = 8'hA5;
        frame_len = 4'd1;
        oth = 1'b1;
        send_req = 1'b1;
        n = 0;
        for (int i = 0; i < 600; i++) begin
            if (bus_tx) n++;
            step();
        end
        chk(n == 0, "R2 no start on busy bus", n, 0);
        chk(busy, "R9 busy while listening", int'(busy), 1);
        oth = 1'b0;
        wait_rise(n);
        chk(n >= IDLE_T && n <= IDLE_T + 2, "R2 listen ticks", n, IDLE_T);
        check_frame(1);

        // R2: request on a bus already quiet long enough
        repeat (2 * IDLE_T + 40) step();
        fr[0] = 8'h3C;
        fr[1] = 8'hFF;
        frame_len = 4'd2;
        send_req = 1'b1;
        wait_rise(n);
        chk(n <= 2, "R2 prompt start on quiet bus", n, 2);
        check_frame(2);

        // R10: longest frame, every byte index
        tp = 2;
        for (int b = 0; b < MAXB; b++) fr[b] = 8'($urandom);
        frame_len = 4'(MAXB);
        send_req = 1'b1;
        wait_rise(n);
        check_frame(MAXB);

        // Directed loss at the first bit, then random trials
        run_trial(1, 2);
        run_trial(1, 1);
        for (int t = 0; t < 8; t++)
            run_trial(1 + int'($urandom % 2), t % 4);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule